// File: doc/BRIEF.md
# Shared microcoded memory self-test controller

The block is one self-test engine that checks several embedded RAMs of different depths. It steps through march-style test algorithms held as microinstructions in an internal ROM. One shared address counter and one data generator serve every memory. A thin wrapper sits in front of each RAM. The wrapper drops addresses beyond its own depth, issues the read and write operations, compares read data against the expected pattern and keeps a sticky fail flag.

Two programs are built in. Program 0 stores only the first half of a symmetric algorithm. A mark instruction loads a recurrence register. A replay instruction then runs the marked section a second time with the address direction reversed and both the written data and the expected read data complemented. Program 1 is a three-element march with no replay.

All selected memories run the same program in lockstep. A shared one-cycle sync strobe opens each element and re-arms every wrapper. The controller moves to the next microinstruction only after every selected wrapper has covered its whole address range.

Top module: `mbist_hub`

## Requirements
- R1: After reset `done` is 0, every `fail` bit is 0 and no `mem_en` bit is asserted.
- R2: With `algo_sel`=0, each memory of depth d receives 3d writes. First come d writes of all-zero data at addresses 0..d-1 in ascending order, then d writes of all-ones data at ascending addresses. Over the run it also receives 3d reads.
- R3: The replayed section visits addresses in descending order, d-1 down to 0, so the last d writes of an `algo_sel`=0 run go to d-1, d-2, ..., 0.
- R4: In the replayed section the written data is the complement of the first pass (all-zero instead of all-ones), and reads expect the complemented value (all-ones). A fault-free memory therefore does not fail.
- R5: A wrapper never asserts `mem_en` with an address at or beyond its memory's depth. Smaller memories finish each element early and stay idle while larger ones continue.
- R6: A read that returns data different from the expected pattern sets that memory's `fail` bit. The bit stays set until the next accepted `start`, and no other memory's bit is affected.
- R7: `done` rises when the program reaches its end instruction and stays high until the next `start`. No memory access is issued while `done` is high. A `start` accepted while idle or done clears all `fail` bits.
- R8: `sync` is a one-cycle pulse at the start of each march element: 4 pulses for `algo_sel`=0 and 3 for `algo_sel`=1.
- R9: A memory whose `mem_active` bit is 0 receives no accesses and keeps `fail` at 0, even if it is faulty.
- R10: With `algo_sel`=1 each memory of depth d receives the same 3d-write pattern as in R2 and R3, but only 2d reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test run; accepted while idle or done |
| algo_sel | input | 1 | 0 = section plus mirrored replay, 1 = three-element march |
| mem_active | input | NMEM | Per-memory select for the run |
| done | output | 1 | Program reached its end instruction |
| sync | output | 1 | One-cycle strobe at each element start |
| fail | output | NMEM | Sticky per-memory mismatch flag |
| mem_en | output | NMEM | Per-memory access enable |
| mem_we | output | NMEM | Per-memory write enable (1 = write) |
| mem_addr | output | NMEM*AW | Per-memory address, memory i at bits [i*AW +: AW] |
| mem_wdata | output | NMEM*DW | Per-memory write data |
| mem_rdata | input | NMEM*DW | Per-memory read data, valid one cycle after a read enable |

## Verification
The hardest situation to reach is a replayed section whose mirrored direction, complemented data and complemented expectation must all be correct at the same time, on memories whose depths differ from the shared address range. The stimulus records every write each RAM model sees across complete runs on depths 16, 10 and 5. Faults are injected as stuck-at bits at addresses read in the first pass and in the mirrored pass. This shows both that a wrong polarity flips a clean memory to fail and that a real defect is reported only on its own memory.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [1:0] {K_ELEM, K_MARK, K_REPLAY, K_END} kind_e;

  typedef struct packed {
    kind_e kind;
    logic  down;  // address direction, 1 = descending
    logic  two;   // element has a second operation
    logic  wr0;   // first op: 1 = write, 0 = read
    logic  v0;    // first op data / expected bit
    logic  wr1;
    logic  v1;
  } minstr_t;

  localparam int unsigned PC_PROG0 = 0;
  localparam int unsigned PC_PROG1 = 6;
endpackage

// File: rtl/mbist_rom.sv
module mbist_rom
  import mbist_pkg::*;
#(
  parameter int PCW = 4
) (
  input  logic [PCW-1:0] pc,
  output minstr_t        ins
);
  function automatic minstr_t mk(kind_e k, logic dn, logic two, logic w0, logic v0,
                                 logic w1, logic v1);
    minstr_t m;
    m.kind = k; m.down = dn; m.two = two;
    m.wr0 = w0; m.v0 = v0; m.wr1 = w1; m.v1 = v1;
    return m;
  endfunction

  always_comb begin
    case (pc)
      // program 0: w0 ; mark ; up(r0,w1) ; replay mirrored ; up(r0)
      4'd0:    ins = mk(K_ELEM,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      4'd1:    ins = mk(K_MARK,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      4'd2:    ins = mk(K_ELEM,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      4'd3:    ins = mk(K_REPLAY, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      4'd4:    ins = mk(K_ELEM,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      4'd5:    ins = mk(K_END,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      // program 1: w0 ; up(r0,w1) ; down(r1,w0)
      4'd6:    ins = mk(K_ELEM,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      4'd7:    ins = mk(K_ELEM,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
      4'd8:    ins = mk(K_ELEM,   1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      default: ins = mk(K_END,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endcase
  end
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
  import mbist_pkg::*;
#(
  parameter int AW  = 4,
  parameter int PCW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          algo_sel,
  input  logic          all_done,
  output logic          clr,
  output logic          run,
  output logic [AW-1:0] addr,
  output logic          dir_dn,
  output logic          we,
  output logic          wval,
  output logic          step_last,
  output logic          sync,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_FIN} st_e;

  st_e             st;
  logic [PCW-1:0]  pc, rec_start;
  logic            mirror, step;
  minstr_t         ins, cur;

  mbist_rom #(.PCW(PCW)) u_rom (.pc(pc), .ins(ins));

  assign clr       = start && (st == S_IDLE || st == S_FIN);
  assign run       = (st == S_RUN);
  assign step_last = !cur.two || step;
  assign we        = step ? cur.wr1 : cur.wr0;
  assign wval      = (step ? cur.v1 : cur.v0) ^ mirror;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; rec_start <= '0; mirror <= 1'b0;
      step <= 1'b0; addr <= '0; dir_dn <= 1'b0; sync <= 1'b0;
      done <= 1'b0; cur <= '0;
    end else begin
      sync <= 1'b0;
      case (st)
        S_IDLE, S_FIN: if (start) begin
          pc     <= algo_sel ? PCW'(PC_PROG1) : PCW'(PC_PROG0);
          mirror <= 1'b0;
          done   <= 1'b0;
          st     <= S_FETCH;
        end
        S_FETCH: case (ins.kind)
          K_ELEM: begin
            cur    <= ins;
            dir_dn <= ins.down ^ mirror;
            addr   <= (ins.down ^ mirror) ? '1 : '0;
            step   <= 1'b0;
            sync   <= 1'b1;
            st     <= S_RUN;
          end
          K_MARK: begin
            rec_start <= pc + 1'b1;
            pc        <= pc + 1'b1;
          end
          K_REPLAY: begin
            if (!mirror) begin
              mirror <= 1'b1;
              pc     <= rec_start;
            end else begin
              mirror <= 1'b0;
              pc     <= pc + 1'b1;
            end
          end
          default: begin
            done <= 1'b1;
            st   <= S_FIN;
          end
        endcase
        S_RUN: begin
          if (all_done && !sync) begin
            pc <= pc + 1'b1;
            st <= S_FETCH;
          end else if (step_last) begin
            step <= 1'b0;
            if (dir_dn) begin
              if (addr != '0) addr <= addr - 1'b1;
            end else begin
              if (addr != '1) addr <= addr + 1'b1;
            end
          end else begin
            step <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sync |=> !sync); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> !run); // R7
endmodule

// File: rtl/mbist_wrap.sv
module mbist_wrap #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act,
  input  logic          clr,
  input  logic          run,
  input  logic          sync,
  input  logic [AW-1:0] addr,
  input  logic          dir_dn,
  input  logic          we,
  input  logic          wval,
  input  logic          step_last,
  output logic          elem_done,
  output logic          fail,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  logic          in_range, at_end, fire;
  logic          chk_q;
  logic [DW-1:0] exp_q;

  assign in_range  = (int'(addr) < DEPTH);
  assign at_end    = dir_dn ? (addr == '0) : (int'(addr) == DEPTH - 1);
  assign fire      = act && run && in_range && (!elem_done || sync);
  assign mem_en    = fire;
  assign mem_we    = we;
  assign mem_addr  = addr;
  assign mem_wdata = {DW{wval}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_done <= 1'b0; fail <= 1'b0; chk_q <= 1'b0; exp_q <= '0;
    end else if (clr) begin
      elem_done <= 1'b0; fail <= 1'b0; chk_q <= 1'b0;
    end else begin
      elem_done <= (elem_done && !sync) || (fire && step_last && at_end);
      chk_q     <= fire && !we;
      exp_q     <= {DW{wval}};
      if (chk_q && (mem_rdata != exp_q)) fail <= 1'b1;
    end
  end

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(mem_addr) < DEPTH)); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail); // R6
endmodule

// File: rtl/mbist_hub.sv
module mbist_hub #(
  parameter int NMEM = 3,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter logic [NMEM-1:0][AW:0] DEPTHS = {5'd5, 5'd10, 5'd16}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               algo_sel,
  input  logic [NMEM-1:0]    mem_active,
  output logic               done,
  output logic               sync,
  output logic [NMEM-1:0]    fail,
  output logic [NMEM-1:0]    mem_en,
  output logic [NMEM-1:0]    mem_we,
  output logic [NMEM*AW-1:0] mem_addr,
  output logic [NMEM*DW-1:0] mem_wdata,
  input  logic [NMEM*DW-1:0] mem_rdata
);
  localparam int PCW = 4;

  logic          clr, run, dir_dn, we, wval, step_last, all_done;
  logic [AW-1:0] addr;
  logic [NMEM-1:0] edone;

  assign all_done = &(edone | ~mem_active);

  mbist_seq #(.AW(AW), .PCW(PCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .all_done(all_done), .clr(clr), .run(run), .addr(addr), .dir_dn(dir_dn),
    .we(we), .wval(wval), .step_last(step_last), .sync(sync), .done(done)
  );

  for (genvar i = 0; i < NMEM; i++) begin : g_wrap
    mbist_wrap #(.AW(AW), .DW(DW), .DEPTH(int'(DEPTHS[i]))) u_wrap (
      .clk(clk), .rst_n(rst_n), .act(mem_active[i]), .clr(clr), .run(run),
      .sync(sync), .addr(addr), .dir_dn(dir_dn), .we(we), .wval(wval),
      .step_last(step_last), .elem_done(edone[i]), .fail(fail[i]),
      .mem_en(mem_en[i]), .mem_we(mem_we[i]),
      .mem_addr(mem_addr[i*AW +: AW]), .mem_wdata(mem_wdata[i*DW +: DW]),
      .mem_rdata(mem_rdata[i*DW +: DW])
    );
  end
endmodule

// File: tb/test_mbist_hub.sv
module test_mbist_hub;
  localparam int NMEM = 3, AW = 4, DW = 8, LOGN = 512;
  localparam int DEP [NMEM] = '{16, 10, 5};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, algo_sel = 1'b0;
  logic [NMEM-1:0] mem_active = '1;
  logic done, sync;
  logic [NMEM-1:0] fail, mem_en, mem_we;
  logic [NMEM*AW-1:0] mem_addr;
  logic [NMEM*DW-1:0] mem_wdata;
  logic [NMEM*DW-1:0] mem_rdata = '0;

  mbist_hub i_mbist_hub (.*);

  always #2 clk = ~clk;

  logic [DW-1:0] ram [NMEM][16];
  logic          f_en [NMEM];
  logic [AW-1:0] f_addr [NMEM];
  int            f_bit [NMEM];
  logic          f_val [NMEM];
  logic [AW-1:0] wa [NMEM][LOGN];
  logic [DW-1:0] wd [NMEM][LOGN];
  int wcnt [NMEM];
  int rcnt [NMEM];
  int viol = 0, syncs = 0, checks = 0, failures = 0;

  initial for (int i = 0; i < NMEM; i++) begin
    f_en[i] = 1'b0; f_addr[i] = '0; f_bit[i] = 0; f_val[i] = 1'b0;
    wcnt[i] = 0; rcnt[i] = 0;
  end

  always @(posedge clk) begin
    if (sync) syncs <= syncs + 1;
    for (int i = 0; i < NMEM; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = mem_addr[i*AW +: AW];
      if (mem_en[i]) begin
        if (int'(a) >= DEP[i]) viol <= viol + 1;
        if (mem_we[i]) begin
          ram[i][a] <= mem_wdata[i*DW +: DW];
          if (wcnt[i] < LOGN) begin
            wa[i][wcnt[i]] <= a;
            wd[i][wcnt[i]] <= mem_wdata[i*DW +: DW];
          end
          wcnt[i] <= wcnt[i] + 1;
        end else begin
          d = ram[i][a];
          if (f_en[i] && a == f_addr[i]) d[f_bit[i]] = f_val[i];
          mem_rdata[i*DW +: DW] <= d;
          rcnt[i] <= rcnt[i] + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_prog(input logic sel, input logic [NMEM-1:0] act);
    int n = 0;
    @(negedge clk);
    algo_sel = sel; mem_active = act; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R7 done reached", int'(done), 1);
  endtask

  // write pattern shared by both programs: up 0s, up 1s, down 0s
  task automatic verify_writes(input int i, input int wb, input string tag);
    int d = DEP[i];
    int bad_up = 0, bad_dn = 0, bad_dat = 0;
    chk(wcnt[i] - wb == 3 * d, {tag, " write count"}, wcnt[i] - wb, 3 * d);
    for (int k = 0; k < 3 * d; k++) begin
      int seg = k / d, off = k % d;
      int ea = (seg == 2) ? d - 1 - off : off;
      logic [DW-1:0] ed = (seg == 1) ? '1 : '0;
      if (int'(wa[i][wb + k]) != ea) begin
        if (seg == 2) bad_dn++; else bad_up++;
      end
      if (wd[i][wb + k] != ed) bad_dat++;
    end
    chk(bad_up == 0, {tag, " R2 ascending order"}, bad_up, 0);
    chk(bad_dn == 0, {tag, " R3 descending replay order"}, bad_dn, 0);
    chk(bad_dat == 0, {tag, " R4 data polarity"}, bad_dat, 0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(fail == '0, "R1 fail after reset", int'(fail), 0);
    chk(mem_en == '0, "R1 no enables after reset", int'(mem_en), 0);
  endtask

  task automatic t_clean_prog0;
    int wb [NMEM];
    int rb [NMEM];
    int s0 = syncs;
    for (int i = 0; i < NMEM; i++) begin wb[i] = wcnt[i]; rb[i] = rcnt[i]; end
    run_prog(1'b0, 3'b111);
    for (int i = 0; i < NMEM; i++) begin
      verify_writes(i, wb[i], "prog0");
      chk(rcnt[i] - rb[i] == 3 * DEP[i], "R2 read count", rcnt[i] - rb[i], 3 * DEP[i]);
    end
    chk(fail == '0, "R4 clean memories pass after mirrored pass", int'(fail), 0);
    chk(syncs - s0 == 4, "R8 sync pulses prog0", syncs - s0, 4);
    chk(viol == 0, "R5 no out-of-range access", viol, 0);
  endtask

  task automatic t_fault_prog0;
    f_en[1] = 1'b1; f_addr[1] = 4'd3; f_bit[1] = 2; f_val[1] = 1'b1;
    run_prog(1'b0, 3'b111);
    chk(fail == 3'b010, "R6 stuck-at-1 flags only memory 1", int'(fail), 2);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R7 done holds", int'(done), 1);
    chk(fail == 3'b010, "R6 fail sticky after done", int'(fail), 2);
    chk(mem_en == '0, "R7 no access while done", int'(mem_en), 0);
  endtask

  task automatic t_inactive;
    int w1 = wcnt[1], r1 = rcnt[1];
    @(negedge clk);
    mem_active = 3'b101; algo_sel = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail == '0, "R7 start clears fail", int'(fail), 0);
    while (!done) @(negedge clk);
    chk(fail[1] == 1'b0, "R9 inactive faulty memory not flagged", int'(fail[1]), 0);
    chk(wcnt[1] - w1 + rcnt[1] - r1 == 0, "R9 inactive memory untouched",
        wcnt[1] - w1 + rcnt[1] - r1, 0);
    chk(fail == '0, "R9 active memories pass", int'(fail), 0);
    f_en[1] = 1'b0;
  endtask

  task automatic t_prog1;
    int wb [NMEM];
    int rb [NMEM];
    int s0 = syncs;
    for (int i = 0; i < NMEM; i++) begin wb[i] = wcnt[i]; rb[i] = rcnt[i]; end
    f_en[2] = 1'b1; f_addr[2] = 4'd4; f_bit[2] = 0; f_val[2] = 1'b0;
    run_prog(1'b1, 3'b111);
    for (int i = 0; i < NMEM; i++) begin
      verify_writes(i, wb[i], "R10 prog1");
      chk(rcnt[i] - rb[i] == 2 * DEP[i], "R10 read count", rcnt[i] - rb[i], 2 * DEP[i]);
    end
    chk(syncs - s0 == 3, "R8 sync pulses prog1", syncs - s0, 3);
    chk(fail == 3'b100, "R6 stuck-at-0 flags only memory 2", int'(fail), 4);
    chk(viol == 0, "R5 no out-of-range access", viol, 0);
    f_en[2] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_clean_prog0;
    t_fault_prog0;
    t_inactive;
    t_prog1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R7 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule